// File: doc/BRIEF.md
# Two-Domain Pulse-Acknowledge Handshake Controller

This block links two unrelated clock domains with a reduced request/acknowledge protocol. The initiating side (domain A) raises a request level for each transaction when `start` is sampled while idle. The responding side (domain B) brings that level in through a multi-flop synchronizer and detects its rising edge. It answers each new request with an acknowledge one B-cycle wide. It also strobes `req_seen` so local logic in domain B can act on the transaction. The acknowledge never waits for the request to fall.

The acknowledge crosses back as a toggle. Domain B flips a single bit per acknowledge. Domain A synchronizes that bit and recovers one event per flip by comparing it with its delayed copy. On that event domain A drops the request, pulses `done` for one cycle, and then holds the request low for a programmable number of cycles. This low gap lets domain B see the request fall before the next one rises. Any `start` that arrives while a request is pending or during the gap is discarded. Data movement is left to whatever logic uses the strobes.

Top module: `hs_partial_ctrl`

## Requirements
- R1: While either reset is high and on the first cycle after it, `done` and `req_seen` are 0, and no request is pending.
- R2: A `start` sampled high while side A is idle raises the request on the next clk_a edge. Each new request yields exactly one `req_seen` pulse exactly one clk_b cycle wide, together with one flip of the acknowledge toggle.
- R3: For each transaction side A pulses `done` high for exactly one clk_a cycle, on the same edge at which the request falls.
- R4: `done` for a transaction is never asserted before side B has pulsed `req_seen` for that transaction.
- R5: A `start` that arrives while a request is pending has no effect: it causes no extra `req_seen` and no extra `done`.
- R6: After the request falls it stays low for at least GAP_CYCLES+1 clk_a cycles. A `start` during the GAP_CYCLES cycles that follow `done` is ignored.
- R7: Once raised, the request stays high until the acknowledge is recovered in domain A. It falls only together with `done`.
- R8: With `start` held high continuously, transactions repeat back to back. Every one is seen exactly once by side B and completed exactly once by side A.
- R9: With SYNC_STAGES=2 and a clk_b period shorter than (GAP_CYCLES+1) clk_a periods, `done` follows the `start` sample within 6 clk_a plus 4 clk_b periods. This holds whether clk_b is faster or slower than clk_a.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Clock of the initiating domain |
| rst_a | input | 1 | Synchronous active-high reset, domain A |
| start | input | 1 | Request a transaction (domain A, sampled when idle) |
| done | output | 1 | One-cycle strobe: transaction acknowledged (domain A) |
| clk_b | input | 1 | Clock of the responding domain |
| rst_b | input | 1 | Synchronous active-high reset, domain B |
| req_seen | output | 1 | One-cycle strobe: new request detected (domain B) |

## Verification
The properties assume that `start` is synchronous to clk_a. They also assume that both resets are held together long enough to clear every synchronizer stage. The ordering results further assume that a clk_b period is shorter than the request-low gap, so that domain B always observes the request fall. The stimulus keeps within these limits. It sweeps clk_b periods from 4 ns to 14 ns against the 5 ns clk_a, and the default two-cycle gap always leaves the request low for at least 15 ns. It asserts both resets for several edges of each clock, and drives `start` only on clk_a falling edges.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [1:0] {
    A_IDLE = 2'd0,
    A_WAIT = 2'd1,
    A_REST = 2'd2
  } a_state_e;
endpackage

// File: rtl/cdc_sync_chain.sv
module cdc_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= {stg[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hs_side_b.sv
module hs_side_b #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_async,
  output logic ack_tgl,
  output logic seen
);
  logic req_s;
  logic req_d;
  logic rise;

  cdc_sync_chain #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk (clk),
    .rst (rst),
    .d   (req_async),
    .q   (req_s)
  );

  assign rise = req_s & ~req_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_d   <= 1'b0;
      seen    <= 1'b0;
      ack_tgl <= 1'b0;
    end else begin
      req_d   <= req_s;
      seen    <= rise;
      ack_tgl <= ack_tgl ^ rise;
    end
  end
endmodule

// File: rtl/hs_side_a.sv
module hs_side_a
  import hs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int GAP_CYCLES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic ack_tgl_async,
  output logic req_out,
  output logic done
);
  localparam int GW = $clog2(GAP_CYCLES + 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYCLES - 1);

  logic ack_s;
  logic ack_d;
  logic ack_evt;
  a_state_e state;
  logic [GW-1:0] gap_cnt;

  cdc_sync_chain #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk (clk),
    .rst (rst),
    .d   (ack_tgl_async),
    .q   (ack_s)
  );

  assign ack_evt = ack_s ^ ack_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_d   <= 1'b0;
      state   <= A_IDLE;
      req_out <= 1'b0;
      done    <= 1'b0;
      gap_cnt <= '0;
    end else begin
      ack_d <= ack_s;
      done  <= 1'b0;
      unique case (state)
        A_IDLE: begin
          if (start) begin
            req_out <= 1'b1;
            state   <= A_WAIT;
          end
        end
        A_WAIT: begin
          if (ack_evt) begin
            req_out <= 1'b0;
            done    <= 1'b1;
            gap_cnt <= '0;
            state   <= A_REST;
          end
        end
        A_REST: begin
          if (gap_cnt == GAP_LAST) state <= A_IDLE;
          else                     gap_cnt <= gap_cnt + 1'b1;
        end
        default: state <= A_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hs_partial_ctrl.sv
module hs_partial_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int GAP_CYCLES  = 2
) (
  input  logic clk_a,
  input  logic rst_a,
  input  logic start,
  output logic done,
  input  logic clk_b,
  input  logic rst_b,
  output logic req_seen
);
  logic req_line;
  logic ack_toggle;

  hs_side_a #(
    .SYNC_STAGES (SYNC_STAGES),
    .GAP_CYCLES  (GAP_CYCLES)
  ) u_side_a (
    .clk           (clk_a),
    .rst           (rst_a),
    .start         (start),
    .ack_tgl_async (ack_toggle),
    .req_out       (req_line),
    .done          (done)
  );

  hs_side_b #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_side_b (
    .clk       (clk_b),
    .rst       (rst_b),
    .req_async (req_line),
    .ack_tgl   (ack_toggle),
    .seen      (req_seen)
  );
endmodule

// File: rtl/hs_partial_ctrl_chk.sv
module hs_partial_ctrl_chk (
  input logic clk_a,
  input logic rst_a,
  input logic clk_b,
  input logic rst_b,
  input logic start,
  input logic done,
  input logic req_seen,
  input logic req_line,
  input logic ack_toggle
);
  a_r3_done_single: assert property (@(posedge clk_a) disable iff (rst_a)
    done |=> !done);

  a_r3_done_with_fall: assert property (@(posedge clk_a) disable iff (rst_a)
    done |-> $fell(req_line));

  a_r7_fall_only_with_done: assert property (@(posedge clk_a) disable iff (rst_a)
    $fell(req_line) |-> done);

  a_r6_gap_low: assert property (@(posedge clk_a) disable iff (rst_a)
    $fell(req_line) |=> !req_line);

  a_r2_rise_from_start: assert property (@(posedge clk_a) disable iff (rst_a)
    $rose(req_line) |-> $past(start));

  a_r2_seen_single: assert property (@(posedge clk_b) disable iff (rst_b)
    req_seen |=> !req_seen);

  a_r2_toggle_with_seen: assert property (@(posedge clk_b) disable iff (rst_b)
    req_seen |-> (ack_toggle != $past(ack_toggle)));

  a_r2_toggle_only_on_seen: assert property (@(posedge clk_b) disable iff (rst_b)
    !req_seen |-> (ack_toggle == $past(ack_toggle)));
endmodule

bind hs_partial_ctrl hs_partial_ctrl_chk u_chk (
  .clk_a      (clk_a),
  .rst_a      (rst_a),
  .clk_b      (clk_b),
  .rst_b      (rst_b),
  .start      (start),
  .done       (done),
  .req_seen   (req_seen),
  .req_line   (req_line),
  .ack_toggle (ack_toggle)
);

// File: tb/hs_partial_ctrl_bench.sv
`timescale 1ns/100ps
module hs_partial_ctrl_bench;
  localparam int S   = 2;
  localparam int GAP = 2;
  localparam int TA  = 5;

  logic clk_a = 1'b0;
  logic clk_b = 1'b0;
  logic rst_a = 1'b1;
  logic rst_b = 1'b1;
  logic start = 1'b0;
  logic done;
  logic req_seen;
  int   hb = 2;

  int cmp = 0;
  int mis = 0;
  int seen_cnt = 0;
  int done_cnt = 0;
  int seen_wide = 0;
  int done_wide = 0;
  int order_bad = 0;
  logic prev_seen = 1'b0;
  logic prev_done = 1'b0;
  bit   finished = 1'b0;

  hs_partial_ctrl #(.SYNC_STAGES(S), .GAP_CYCLES(GAP)) u_hs_partial_ctrl (
    .clk_a    (clk_a),
    .rst_a    (rst_a),
    .start    (start),
    .done     (done),
    .clk_b    (clk_b),
    .rst_b    (rst_b),
    .req_seen (req_seen)
  );

  always #2.5 clk_a = ~clk_a;
  initial forever #(hb) clk_b = ~clk_b;

  always @(negedge clk_b) begin
    if (rst_b) begin
      seen_cnt = 0; seen_wide = 0; prev_seen = 1'b0;
    end else begin
      if (req_seen) seen_cnt++;
      if (req_seen && prev_seen) seen_wide++;
      prev_seen = req_seen;
    end
  end

  always @(negedge clk_a) begin
    if (rst_a) begin
      done_cnt = 0; done_wide = 0; order_bad = 0; prev_done = 1'b0;
    end else begin
      if (done) begin
        if (seen_cnt <= done_cnt) order_bad++;
        done_cnt++;
      end
      if (done && prev_done) done_wide++;
      prev_done = done;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    cmp++;
    if (!ok) begin
      mis++;
      $display("FAIL %s: actual %0d expected %0d (clk_b half period %0d ns)", req, act, exp, hb);
    end
  endtask

  task automatic apply_reset();
    rst_a = 1'b1; rst_b = 1'b1; start = 1'b0;
    repeat (5) @(negedge clk_b);
    repeat (5) @(negedge clk_a);
    @(negedge clk_b); rst_b = 1'b0;
    @(negedge clk_a); rst_a = 1'b0;
  endtask

  task automatic wait_done(output int cycles);
    cycles = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk_a);
      cycles++;
      if (done) break;
    end
  endtask

  initial begin
    #900000;
    if (!finished) begin
      mis++; cmp++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp, mis);
      $finish;
    end
  end

  initial begin
    int hps[4] = '{2, 3, 5, 7};
    for (int k = 0; k < 4; k++) begin
      int bound_ns, cyc, s0, d0, minn;
      hb = hps[k];
      apply_reset();
      @(negedge clk_a);
      check(done == 1'b0, "R1 done after reset", int'(done), 0);
      check(req_seen == 1'b0, "R1 req_seen after reset", int'(req_seen), 0);
      check(seen_cnt == 0 && done_cnt == 0, "R1 no transaction after reset", seen_cnt + done_cnt, 0);

      // single transaction, latency bound R9
      bound_ns = 6 * TA + 4 * (2 * hb);
      start = 1'b1; @(negedge clk_a); start = 1'b0;
      wait_done(cyc);
      check(done == 1'b1 && cyc * TA <= bound_ns, "R9 latency", cyc * TA, bound_ns);
      repeat (40) @(negedge clk_a);
      check(seen_cnt == 1, "R2 one req_seen per request", seen_cnt, 1);
      check(done_cnt == 1, "R3 one done per request", done_cnt, 1);

      // start while pending is ignored R5
      s0 = seen_cnt; d0 = done_cnt;
      start = 1'b1; @(negedge clk_a); start = 1'b0;
      @(negedge clk_a); start = 1'b1; @(negedge clk_a); start = 1'b0;
      wait_done(cyc);
      repeat (40) @(negedge clk_a);
      check(seen_cnt - s0 == 1, "R5 start while pending (req_seen)", seen_cnt - s0, 1);
      check(done_cnt - d0 == 1, "R5 start while pending (done)", done_cnt - d0, 1);

      // start in the gap right after done is ignored R6
      s0 = seen_cnt; d0 = done_cnt;
      start = 1'b1; @(negedge clk_a); start = 1'b0;
      wait_done(cyc);
      start = 1'b1; @(negedge clk_a); start = 1'b0;
      repeat (40) @(negedge clk_a);
      check(seen_cnt - s0 == 1, "R6 start in gap (req_seen)", seen_cnt - s0, 1);
      check(done_cnt - d0 == 1, "R6 start in gap (done)", done_cnt - d0, 1);

      // held start: back to back R8
      s0 = seen_cnt; d0 = done_cnt;
      minn = (300 * TA) / (bound_ns + (GAP + 2) * TA);
      start = 1'b1;
      repeat (300) @(negedge clk_a);
      start = 1'b0;
      repeat (60) @(negedge clk_a);
      check(seen_cnt - s0 == done_cnt - d0, "R8 seen equals done", seen_cnt - s0, done_cnt - d0);
      check(done_cnt - d0 >= minn, "R8 back-to-back rate", done_cnt - d0, minn);

      check(order_bad == 0, "R4 done after req_seen", order_bad, 0);
      check(done_wide == 0, "R3 done one cycle wide", done_wide, 0);
      check(seen_wide == 0, "R2 req_seen one cycle wide", seen_wide, 0);
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp, mis);
    $finish;
  end
endmodule